// File: doc/BRIEF.md
# Reorder Buffer with In-Order Retirement

This block keeps instructions in program order while their results arrive out of order. The decoder claims a slot at the tail of a circular queue and receives a tag, which is the slot index. Execution units later return the result, the store address and data, the branch target and an exception flag for that tag. None of these values reaches architectural state at that point.

Retirement looks only at the oldest slot. When that slot has completed, its register write, memory write or branch outcome is presented on the retire ports for one cycle, and the slot is released. If the oldest completed slot carries an exception flag, nothing is written. Its PC is reported and every slot is discarded, so all older work has already retired and no younger work ever does. After that flush, tags start again from zero.

Top module: `rob_core`

## Requirements
- R1: After reset the buffer is empty (`empty_o`=1, `full_o`=0, `alloc_ready_o`=1). No retire, write, branch or exception output is asserted.
- R2: When `alloc_valid_i` and `alloc_ready_o` are both high in a cycle, a slot is claimed. `alloc_tag_o` shows its tag in that same cycle. Tags run 0,1,2,… modulo DEPTH from reset or from a flush.
- R3: A completion writes its data only into the slot named by `cmpl_tag_i`. A completion aimed at a slot that is not allocated is ignored. No register, memory or branch output is asserted except for a retiring slot.
- R4: At most one slot retires per cycle. It is always the oldest, and only once it has completed. Retirement follows allocation order whatever the completion order. The retire outputs appear combinationally in the first cycle in which the oldest slot is complete, with `commit_tag_o` giving its tag.
- R5: A retiring slot that was allocated with `alloc_has_dest_i`=1 drives `rf_we_o`=1, `rf_waddr_o` = its destination and `rf_wdata_o` = its completed value.
- R6: A retiring slot allocated with `alloc_is_store_i`=1 drives `mem_we_o`=1 with the store address and data it received at completion. Memory is written at no other time.
- R7: A retiring slot allocated with `alloc_is_branch_i`=1 drives `br_valid_o`=1 and `br_target_o` = its completed target.
- R8: With DEPTH slots occupied, `full_o`=1 and `alloc_ready_o`=0, and an allocation request has no effect.
- R9: When the oldest slot is complete with its exception flag set, `exc_valid_o`=1 and `exc_pc_o` = its PC. In that cycle there is no retire, register or memory write, and no allocation is accepted. In the next cycle the buffer is empty, all younger slots are gone, and the next tag is 0.
- R10: `empty_o` is 1 exactly when no slot is occupied. `full_o` and `empty_o` are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid_i | input | 1 | Decoder requests a slot |
| alloc_has_dest_i | input | 1 | Instruction writes a register |
| alloc_is_store_i | input | 1 | Instruction is a store |
| alloc_is_branch_i | input | 1 | Instruction is a branch |
| alloc_dest_i | input | AREG_W | Destination register index |
| alloc_pc_i | input | XLEN | Instruction PC |
| alloc_ready_o | output | 1 | A slot can be claimed this cycle |
| alloc_tag_o | output | IDX_W | Tag of the slot being claimed |
| cmpl_valid_i | input | 1 | A unit returns a result |
| cmpl_tag_i | input | IDX_W | Slot the result belongs to |
| cmpl_exc_i | input | 1 | The instruction raised an exception |
| cmpl_value_i | input | XLEN | Result value |
| cmpl_st_addr_i | input | XLEN | Store address |
| cmpl_st_data_i | input | XLEN | Store data |
| cmpl_br_target_i | input | XLEN | Resolved branch target |
| commit_valid_o | output | 1 | Oldest slot retires this cycle |
| commit_tag_o | output | IDX_W | Tag of the oldest slot |
| commit_pc_o | output | XLEN | PC of the oldest slot |
| rf_we_o | output | 1 | Register file write enable |
| rf_waddr_o | output | AREG_W | Register file write index |
| rf_wdata_o | output | XLEN | Register file write data |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | XLEN | Memory write address |
| mem_wdata_o | output | XLEN | Memory write data |
| br_valid_o | output | 1 | A branch retires |
| br_target_o | output | XLEN | Retired branch target |
| exc_valid_o | output | 1 | Exception taken, buffer flushed |
| exc_pc_o | output | XLEN | PC of the faulting instruction |
| full_o | output | 1 | All slots occupied |
| empty_o | output | 1 | No slot occupied |

## Verification
The assertions check several properties on every cycle. Retirement tags advance by one between flushes, and allocation tags do the same. The two flags are never both high, and a full buffer refuses allocation. An exception cycle writes nothing and leaves the buffer empty one cycle later. Some behaviour can only be shown by the bench's scenarios, which compare every output against a queue model on each cycle. These include: the retired values equal what was completed, even when completions arrive in reverse or scrambled order; stale completions after a flush are ignored; and a faulting store never reaches memory.

// File: rtl/rob_pkg.sv
package rob_pkg;
    localparam int XLEN   = 32;
    localparam int AREG_W = 5;

    typedef struct packed {
        logic              valid;
        logic              done;
        logic              exc;
        logic              has_dest;
        logic              is_store;
        logic              is_branch;
        logic [AREG_W-1:0] dest;
        logic [XLEN-1:0]   value;
        logic [XLEN-1:0]   st_addr;
        logic [XLEN-1:0]   st_data;
        logic [XLEN-1:0]   br_target;
        logic [XLEN-1:0]   pc;
    } rob_entry_t;
endpackage

// File: rtl/rob_ptr_ctrl.sv
module rob_ptr_ctrl #(
    parameter int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic             flush,
    output logic [IDX_W-1:0] head_idx,
    output logic [IDX_W-1:0] tail_idx,
    output logic             full,
    output logic             empty
);
    typedef struct packed {
        logic [IDX_W:0] head;
        logic [IDX_W:0] tail;
    } ptr_t;

    ptr_t s_q, s_d;

    always_comb begin
        s_d = s_q;
        if (flush) begin
            s_d.head = '0;
            s_d.tail = '0;
        end else begin
            if (push) s_d.tail = s_q.tail + (IDX_W+1)'(1);
            if (pop)  s_d.head = s_q.head + (IDX_W+1)'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign head_idx = s_q.head[IDX_W-1:0];
    assign tail_idx = s_q.tail[IDX_W-1:0];
    assign empty    = (s_q.head == s_q.tail);
    assign full     = (s_q.head[IDX_W] != s_q.tail[IDX_W]) &&
                      (s_q.head[IDX_W-1:0] == s_q.tail[IDX_W-1:0]);
endmodule

// File: rtl/rob_store.sv
module rob_store import rob_pkg::*; #(
    parameter int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             alloc_we,
    input  logic [IDX_W-1:0] alloc_idx,
    input  rob_entry_t       alloc_entry,
    input  logic             cmpl_we,
    input  logic [IDX_W-1:0] cmpl_idx,
    input  logic             cmpl_exc,
    input  logic [XLEN-1:0]  cmpl_value,
    input  logic [XLEN-1:0]  cmpl_st_addr,
    input  logic [XLEN-1:0]  cmpl_st_data,
    input  logic [XLEN-1:0]  cmpl_br_target,
    input  logic             retire,
    input  logic [IDX_W-1:0] head_idx,
    output rob_entry_t       head_entry
);
    typedef struct packed {
        rob_entry_t [DEPTH-1:0] ent;
    } store_t;

    store_t s_q, s_d;

    always_comb begin
        s_d = s_q;
        if (flush) begin
            for (int i = 0; i < DEPTH; i++) begin
                s_d.ent[i].valid = 1'b0;
                s_d.ent[i].done  = 1'b0;
            end
        end else begin
            // completion lands only in an occupied slot
            if (cmpl_we && s_q.ent[cmpl_idx].valid) begin
                s_d.ent[cmpl_idx].done      = 1'b1;
                s_d.ent[cmpl_idx].exc       = cmpl_exc;
                s_d.ent[cmpl_idx].value     = cmpl_value;
                s_d.ent[cmpl_idx].st_addr   = cmpl_st_addr;
                s_d.ent[cmpl_idx].st_data   = cmpl_st_data;
                s_d.ent[cmpl_idx].br_target = cmpl_br_target;
            end
            if (retire) begin
                s_d.ent[head_idx].valid = 1'b0;
                s_d.ent[head_idx].done  = 1'b0;
            end
            if (alloc_we) begin
                s_d.ent[alloc_idx]       = alloc_entry;
                s_d.ent[alloc_idx].valid = 1'b1;
                s_d.ent[alloc_idx].done  = 1'b0;
                s_d.ent[alloc_idx].exc   = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign head_entry = s_q.ent[head_idx];
endmodule

// File: rtl/rob_commit.sv
module rob_commit import rob_pkg::*; (
    input  logic              empty,
    input  rob_entry_t        head,
    output logic              pop,
    output logic              flush,
    output logic              rf_we,
    output logic [AREG_W-1:0] rf_waddr,
    output logic [XLEN-1:0]   rf_wdata,
    output logic              mem_we,
    output logic [XLEN-1:0]   mem_addr,
    output logic [XLEN-1:0]   mem_wdata,
    output logic              br_valid,
    output logic [XLEN-1:0]   br_target,
    output logic [XLEN-1:0]   exc_pc
);
    logic head_ready;

    always_comb begin
        head_ready = !empty && head.valid && head.done;
        pop        = head_ready && !head.exc;
        flush      = head_ready &&  head.exc;
        rf_we      = pop && head.has_dest;
        rf_waddr   = head.dest;
        rf_wdata   = head.value;
        mem_we     = pop && head.is_store;
        mem_addr   = head.st_addr;
        mem_wdata  = head.st_data;
        br_valid   = pop && head.is_branch;
        br_target  = head.br_target;
        exc_pc     = head.pc;
    end
endmodule

// File: rtl/rob_core.sv
module rob_core import rob_pkg::*; #(
    parameter int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_valid_i,
    input  logic              alloc_has_dest_i,
    input  logic              alloc_is_store_i,
    input  logic              alloc_is_branch_i,
    input  logic [AREG_W-1:0] alloc_dest_i,
    input  logic [XLEN-1:0]   alloc_pc_i,
    output logic              alloc_ready_o,
    output logic [IDX_W-1:0]  alloc_tag_o,
    input  logic              cmpl_valid_i,
    input  logic [IDX_W-1:0]  cmpl_tag_i,
    input  logic              cmpl_exc_i,
    input  logic [XLEN-1:0]   cmpl_value_i,
    input  logic [XLEN-1:0]   cmpl_st_addr_i,
    input  logic [XLEN-1:0]   cmpl_st_data_i,
    input  logic [XLEN-1:0]   cmpl_br_target_i,
    output logic              commit_valid_o,
    output logic [IDX_W-1:0]  commit_tag_o,
    output logic [XLEN-1:0]   commit_pc_o,
    output logic              rf_we_o,
    output logic [AREG_W-1:0] rf_waddr_o,
    output logic [XLEN-1:0]   rf_wdata_o,
    output logic              mem_we_o,
    output logic [XLEN-1:0]   mem_addr_o,
    output logic [XLEN-1:0]   mem_wdata_o,
    output logic              br_valid_o,
    output logic [XLEN-1:0]   br_target_o,
    output logic              exc_valid_o,
    output logic [XLEN-1:0]   exc_pc_o,
    output logic              full_o,
    output logic              empty_o
);
    logic             pop, flush, push, full, empty;
    logic [IDX_W-1:0] head_idx, tail_idx;
    rob_entry_t       head_entry, new_entry;

    assign push = alloc_valid_i && !full && !flush;

    always_comb begin
        new_entry           = '0;
        new_entry.has_dest  = alloc_has_dest_i;
        new_entry.is_store  = alloc_is_store_i;
        new_entry.is_branch = alloc_is_branch_i;
        new_entry.dest      = alloc_dest_i;
        new_entry.pc        = alloc_pc_i;
    end

    rob_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push),
        .pop      (pop),
        .flush    (flush),
        .head_idx (head_idx),
        .tail_idx (tail_idx),
        .full     (full),
        .empty    (empty)
    );

    rob_store #(.DEPTH(DEPTH)) u_store (
        .clk            (clk),
        .rst_n          (rst_n),
        .flush          (flush),
        .alloc_we       (push),
        .alloc_idx      (tail_idx),
        .alloc_entry    (new_entry),
        .cmpl_we        (cmpl_valid_i),
        .cmpl_idx       (cmpl_tag_i),
        .cmpl_exc       (cmpl_exc_i),
        .cmpl_value     (cmpl_value_i),
        .cmpl_st_addr   (cmpl_st_addr_i),
        .cmpl_st_data   (cmpl_st_data_i),
        .cmpl_br_target (cmpl_br_target_i),
        .retire         (pop),
        .head_idx       (head_idx),
        .head_entry     (head_entry)
    );

    rob_commit u_commit (
        .empty     (empty),
        .head      (head_entry),
        .pop       (pop),
        .flush     (flush),
        .rf_we     (rf_we_o),
        .rf_waddr  (rf_waddr_o),
        .rf_wdata  (rf_wdata_o),
        .mem_we    (mem_we_o),
        .mem_addr  (mem_addr_o),
        .mem_wdata (mem_wdata_o),
        .br_valid  (br_valid_o),
        .br_target (br_target_o),
        .exc_pc    (exc_pc_o)
    );

    assign alloc_ready_o  = !full && !flush;
    assign alloc_tag_o    = tail_idx;
    assign commit_valid_o = pop;
    assign commit_tag_o   = head_idx;
    assign commit_pc_o    = head_entry.pc;
    assign exc_valid_o    = flush;
    assign full_o         = full;
    assign empty_o        = empty;
endmodule

// File: rtl/rob_core_chk.sv
module rob_core_chk #(
    parameter int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             alloc_valid_i,
    input logic             alloc_ready_o,
    input logic [IDX_W-1:0] alloc_tag_o,
    input logic             commit_valid_o,
    input logic [IDX_W-1:0] commit_tag_o,
    input logic             rf_we_o,
    input logic             mem_we_o,
    input logic             br_valid_o,
    input logic             exc_valid_o,
    input logic             full_o,
    input logic             empty_o
);
    logic [IDX_W-1:0] next_retire_q, next_alloc_q;

    always_ff @(posedge clk) begin
        if (!rst_n || exc_valid_o) begin
            next_retire_q <= '0;
            next_alloc_q  <= '0;
        end else begin
            if (commit_valid_o) next_retire_q <= next_retire_q + IDX_W'(1);
            if (alloc_valid_i && alloc_ready_o) next_alloc_q <= next_alloc_q + IDX_W'(1);
        end
    end

    // R4
    retire_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit_valid_o |-> (commit_tag_o == next_retire_q));

    // R2
    alloc_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_valid_i && alloc_ready_o) |-> (alloc_tag_o == next_alloc_q));

    // R2
    alloc_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_valid_i && alloc_ready_o) |=> !empty_o);

    // R8
    full_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full_o |-> !alloc_ready_o);

    // R10
    flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(full_o && empty_o));

    // R9
    exc_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid_o |-> !(rf_we_o || mem_we_o || commit_valid_o || alloc_ready_o));

    // R9
    exc_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid_o |=> empty_o);

    // R3
    write_needs_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we_o || mem_we_o || br_valid_o) |-> (commit_valid_o && !empty_o));
endmodule

bind rob_core rob_core_chk #(.DEPTH(DEPTH)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .alloc_valid_i  (alloc_valid_i),
    .alloc_ready_o  (alloc_ready_o),
    .alloc_tag_o    (alloc_tag_o),
    .commit_valid_o (commit_valid_o),
    .commit_tag_o   (commit_tag_o),
    .rf_we_o        (rf_we_o),
    .mem_we_o       (mem_we_o),
    .br_valid_o     (br_valid_o),
    .exc_valid_o    (exc_valid_o),
    .full_o         (full_o),
    .empty_o        (empty_o)
);

// File: tb/rob_core_test.sv
`timescale 1ns/1ps
module rob_core_test;
    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        a_valid = 0, a_hd = 0, a_st = 0, a_br = 0;
    logic [4:0]  a_dest = '0;
    logic [31:0] a_pc = '0;
    logic        c_valid = 0, c_exc = 0;
    logic [3:0]  c_tag = '0;
    logic [31:0] c_val = '0, c_addr = '0, c_data = '0, c_bt = '0;

    logic        alloc_ready_o, commit_valid_o, rf_we_o, mem_we_o, br_valid_o;
    logic        exc_valid_o, full_o, empty_o;
    logic [3:0]  alloc_tag_o, commit_tag_o;
    logic [4:0]  rf_waddr_o;
    logic [31:0] commit_pc_o, rf_wdata_o, mem_addr_o, mem_wdata_o, br_target_o, exc_pc_o;

    int checks = 0, errors = 0;

    // behavioural model: queue of tags in program order plus per-tag records
    int          q[$];
    int          next_tag = 0;
    bit          mv[DEPTH], md[DEPTH], mx[DEPTH], mhd[DEPTH], mst[DEPTH], mbr[DEPTH];
    logic [4:0]  mdest[DEPTH];
    logic [31:0] mval[DEPTH], mad[DEPTH], mdat[DEPTH], mbt[DEPTH], mpc[DEPTH];

    always #2.5 clk = ~clk;

    rob_core #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid_i(a_valid), .alloc_has_dest_i(a_hd), .alloc_is_store_i(a_st),
        .alloc_is_branch_i(a_br), .alloc_dest_i(a_dest), .alloc_pc_i(a_pc),
        .alloc_ready_o(alloc_ready_o), .alloc_tag_o(alloc_tag_o),
        .cmpl_valid_i(c_valid), .cmpl_tag_i(c_tag), .cmpl_exc_i(c_exc),
        .cmpl_value_i(c_val), .cmpl_st_addr_i(c_addr), .cmpl_st_data_i(c_data),
        .cmpl_br_target_i(c_bt),
        .commit_valid_o(commit_valid_o), .commit_tag_o(commit_tag_o), .commit_pc_o(commit_pc_o),
        .rf_we_o(rf_we_o), .rf_waddr_o(rf_waddr_o), .rf_wdata_o(rf_wdata_o),
        .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
        .br_valid_o(br_valid_o), .br_target_o(br_target_o),
        .exc_valid_o(exc_valid_o), .exc_pc_o(exc_pc_o),
        .full_o(full_o), .empty_o(empty_o)
    );

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    task automatic set_alloc(input logic [31:0] pc, input bit hd, input bit st, input bit br);
        a_valid = 1; a_pc = pc; a_dest = pc[6:2]; a_hd = hd; a_st = st; a_br = br;
    endtask

    task automatic set_cmpl(input int tag, input logic [31:0] val, input bit exc);
        c_valid = 1; c_tag = 4'(tag); c_val = val; c_exc = exc;
        c_addr = val ^ 32'hA5A5_0000; c_data = val + 32'd1; c_bt = val + 32'd2;
    endtask

    // one cycle: compare at the low phase, let the edge pass, update model
    task automatic tick();
        int h = 0;
        bit e_empty, e_full, e_commit = 0, e_exc = 0, e_ready;
        e_empty = (q.size() == 0);
        e_full  = (q.size() == DEPTH);
        if (!e_empty) begin
            h = q[0];
            if (md[h]) begin
                if (mx[h]) e_exc = 1; else e_commit = 1;
            end
        end
        e_ready = !e_full && !e_exc;
        #1;
        chk("R10 empty_o", 32'(empty_o), 32'(e_empty));
        chk("R8 full_o", 32'(full_o), 32'(e_full));
        chk("R8/R9 alloc_ready_o", 32'(alloc_ready_o), 32'(e_ready));
        if (a_valid && e_ready) chk("R2 alloc_tag_o", 32'(alloc_tag_o), 32'(next_tag));
        chk("R4 commit_valid_o", 32'(commit_valid_o), 32'(e_commit));
        chk("R9 exc_valid_o", 32'(exc_valid_o), 32'(e_exc));
        if (e_commit) begin
            chk("R4 commit_tag_o", 32'(commit_tag_o), 32'(h));
            chk("R4 commit_pc_o", commit_pc_o, mpc[h]);
            chk("R5 rf_we_o", 32'(rf_we_o), 32'(mhd[h]));
            if (mhd[h]) begin
                chk("R5 rf_waddr_o", 32'(rf_waddr_o), 32'(mdest[h]));
                chk("R5 rf_wdata_o", rf_wdata_o, mval[h]);
            end
            chk("R6 mem_we_o", 32'(mem_we_o), 32'(mst[h]));
            if (mst[h]) begin
                chk("R6 mem_addr_o", mem_addr_o, mad[h]);
                chk("R6 mem_wdata_o", mem_wdata_o, mdat[h]);
            end
            chk("R7 br_valid_o", 32'(br_valid_o), 32'(mbr[h]));
            if (mbr[h]) chk("R7 br_target_o", br_target_o, mbt[h]);
        end else begin
            chk("R3 rf_we_o idle", 32'(rf_we_o), 32'd0);
            chk("R3 mem_we_o idle", 32'(mem_we_o), 32'd0);
            chk("R3 br_valid_o idle", 32'(br_valid_o), 32'd0);
        end
        if (e_exc) chk("R9 exc_pc_o", exc_pc_o, mpc[h]);
        @(posedge clk);
        if (e_exc) begin
            q.delete();
            for (int i = 0; i < DEPTH; i++) begin mv[i] = 0; md[i] = 0; end
            next_tag = 0;
        end else begin
            if (c_valid && mv[c_tag]) begin
                md[c_tag] = 1; mx[c_tag] = c_exc; mval[c_tag] = c_val;
                mad[c_tag] = c_addr; mdat[c_tag] = c_data; mbt[c_tag] = c_bt;
            end
            if (e_commit) begin
                void'(q.pop_front());
                mv[h] = 0; md[h] = 0;
            end
            if (a_valid && e_ready) begin
                q.push_back(next_tag);
                mv[next_tag] = 1; md[next_tag] = 0; mx[next_tag] = 0;
                mhd[next_tag] = a_hd; mst[next_tag] = a_st; mbr[next_tag] = a_br;
                mdest[next_tag] = a_dest; mpc[next_tag] = a_pc;
                next_tag = (next_tag + 1) % DEPTH;
            end
        end
        @(negedge clk);
        a_valid = 0; c_valid = 0; c_exc = 0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        int base;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        #1;
        // R1 reset state
        chk("R1 empty_o", 32'(empty_o), 32'd1);
        chk("R1 full_o", 32'(full_o), 32'd0);
        chk("R1 alloc_ready_o", 32'(alloc_ready_o), 32'd1);
        chk("R1 outputs idle", 32'({commit_valid_o, rf_we_o, mem_we_o, br_valid_o, exc_valid_o}), 32'd0);
        @(negedge clk);

        // R4/R5: four register writers completed in reverse order
        for (int i = 0; i < 4; i++) begin set_alloc(32'h100 + i * 4, 1, 0, 0); tick(); end
        for (int i = 3; i >= 0; i--) begin set_cmpl(i, 32'h1000 + i, 0); tick(); end
        repeat (5) tick();

        // R6/R7: store, branch, plain op; completed youngest first
        set_alloc(32'h200, 0, 1, 0); tick();
        set_alloc(32'h204, 0, 0, 1); tick();
        set_alloc(32'h208, 1, 0, 0); tick();
        set_cmpl(6, 32'h2006, 0); tick();
        set_cmpl(5, 32'h2005, 0); tick();
        set_cmpl(4, 32'h2004, 0); tick();
        repeat (4) tick();

        // R8: fill to capacity, attempt one more, complete scrambled
        for (int i = 0; i < DEPTH; i++) begin set_alloc(32'h300 + i * 4, 1, i % 3 == 0, 0); tick(); end
        set_alloc(32'h3F0, 1, 0, 0); tick();
        tick();
        for (int i = 0; i < DEPTH; i++) begin set_cmpl((i * 7) % DEPTH, 32'h3000 + i, 0); tick(); end
        repeat (DEPTH + 2) tick();

        // R9: exception in the middle, with concurrent allocation and completion
        base = next_tag;
        for (int i = 0; i < 4; i++) begin set_alloc(32'h400 + i * 4, 1, 0, 0); tick(); end
        set_alloc(32'h410, 1, 0, 0); set_cmpl((base + 3) % DEPTH, 32'h4003, 0); tick();
        set_cmpl((base + 1) % DEPTH, 32'h4001, 1); tick();
        set_cmpl(base, 32'h4000, 0); tick();
        repeat (3) tick();

        // R3: stale completion after flush, then a faulting store
        set_cmpl(3, 32'h5003, 0); tick();
        set_alloc(32'h500, 1, 0, 0); tick();
        set_alloc(32'h504, 0, 1, 0); tick();
        set_alloc(32'h508, 1, 0, 0); tick();
        set_alloc(32'h50C, 1, 0, 0); tick();
        repeat (2) tick();
        set_cmpl(1, 32'h5001, 1); tick();
        set_cmpl(0, 32'h5000, 0); tick();
        repeat (3) tick();

        // R2: tags restart at zero after the flush
        set_alloc(32'h600, 1, 0, 0); tick();
        set_cmpl(0, 32'h6000, 0); tick();
        repeat (2) tick();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule